// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block holds the program counter of a small load/store pipeline and decides, cycle by cycle, which address goes out on the one memory port that serves both instruction fetch and data access. Each fetched 32-bit word is latched into an execute slot, where the external execute unit reports whether a conditional branch is taken and where it goes. Jumps are decoded inside the block. Every control transfer is delayed: the instruction that follows a branch or jump is always fetched and executed, never cancelled, and fetch moves to the target only after that delay-slot instruction has been fetched.

Arithmetic and logic instructions finish in two stages, fetch and execute. Loads and stores take a third, memory, stage, and that stage owns the shared port for its cycle. Fetch waits one cycle while it does, and a bubble enters the execute slot. If a taken branch resolves in a cycle where its delay slot could not be fetched, the redirect is held until the delay slot has gone out.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While reset is low and in the first cycle after it rises, the port fetches from address 0 (data-access flag low, write flag low), the execute slot and the memory stage are empty, and no redirect is held.
- R2: A fetch that is not the last fetch before a redirect is followed, in the next fetch, by the address 4 higher.
- R3: A word fetched in one cycle is presented in the next cycle on the execute slot with its fetch address and the valid flag high; after a cycle without a fetch the slot is empty.
- R4: An instruction in the execute slot whose opcode (bits 31:26) is 100011 (load) or 101011 (store) occupies the memory stage in the next cycle with its own address shown; any other opcode leaves the memory stage empty.
- R5: In a memory-stage cycle the port performs a data access: data-access flag high, address equal to the execute unit's address input captured in the previous cycle, write flag high only for a store. No fetch is made, the program counter is held, and the next execute slot is empty.
- R6: Opcode 000010 is a jump whose target is bits 31:28 of (jump address + 4), then instruction bits 25:0, then two zero bits; the execute unit's taken input is not needed for it.
- R7: The taken and target inputs have no effect while the execute slot is empty.
- R8: For a taken branch or jump, the instruction at its address + 4 is fetched and then executed with no flush, and the fetch after that one goes to the target.
- R9: When a branch resolves in a cycle whose fetch is blocked by a memory stage, the redirect is held and applied after the delay slot is fetched in a later cycle.
- R10: When the delay slot itself holds a taken branch, fetch goes first to the first branch's target, for exactly one instruction, and then to the second branch's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 32 | Word read from the shared port; used as the instruction on fetch cycles |
| exu_taken | input | 1 | Execute unit: conditional branch in the execute slot is taken |
| exu_target | input | 32 | Execute unit: target of that branch |
| exu_addr | input | 32 | Execute unit: data address computed for a load or store |
| mem_addr | output | 32 | Address on the shared memory port |
| mem_data_acc | output | 1 | High when the port performs a data access instead of a fetch |
| mem_we | output | 1 | High for a store data access |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_instr | output | 32 | Instruction in the execute slot |
| ex_pc | output | 32 | Address of the instruction in the execute slot |
| mem_stage_valid | output | 1 | Memory stage holds a load or store |
| mem_stage_pc | output | 32 | Address of the instruction in the memory stage |

## Verification
The port address and data-access flags belong to the current cycle's state, so they are checked in the same cycle the model says a fetch or access happens; the execute slot is due one cycle after its fetch and the memory stage one cycle after the execute slot. A redirect shows on the port address in the cycle after the delay slot's fetch, which is one cycle after resolution when fetch is free and later when a memory stage blocks it. The bench compares every output at the falling edge against a behavioural model that is advanced once per cycle and keeps resolved targets in a queue, tagging each expected fetch address with the rule that produced it. Programs mix stalled and unstalled delay slots, back-to-back memory stages, a branch inside a jump's delay slot, and non-taken branches, while the taken input is driven high during every bubble.

// File: rtl/dslot_pkg.sv
// Shared widths, opcodes and slot types for the delayed-branch fetch
// sequencer. Assumes fixed 32-bit instructions with the opcode in the
// top six bits and byte addressing.
package dslot_pkg;
    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int JIDX_W  = 26;
    localparam int STEP    = XLEN / 8;
    localparam int ALIGN_W = $clog2(STEP);
    localparam int SEG_W   = XLEN - JIDX_W - ALIGN_W;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_JUMP  = 6'b000010;
    localparam opc_t OPC_LOAD  = 6'b100011;
    localparam opc_t OPC_STORE = 6'b101011;

    // Execute slot: one fetched instruction and its address.
    typedef struct packed {
        logic  valid;
        word_t instr;
        word_t pc;
    } ex_slot_t;

    // Memory stage: a load or store holding the shared port.
    typedef struct packed {
        logic  valid;
        logic  store;
        word_t pc;
        word_t addr;
    } mem_slot_t;

    function automatic opc_t opc_of(input word_t w);
        return w[XLEN-1 -: OPC_W];
    endfunction

    function automatic logic uses_mem(input word_t w);
        return (opc_of(w) == OPC_LOAD) || (opc_of(w) == OPC_STORE);
    endfunction

    // Jump target: top segment of the incremented address, index, zero pad.
    function automatic word_t jump_dest(input word_t pc, input word_t w);
        word_t inc;
        inc = pc + XLEN'(STEP);
        return {inc[XLEN-1 -: SEG_W], w[JIDX_W-1:0], {ALIGN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dslot_redirect.sv
// Redirect decode for the execute slot. Jumps form their own target;
// any other instruction defers to the execute unit's taken flag. An
// empty slot never redirects. Purely combinational.
module dslot_redirect
    import dslot_pkg::*;
(
    input  ex_slot_t ex,
    input  logic     exu_taken,
    input  word_t    exu_target,
    output logic     redirect,
    output word_t    target
);
    logic is_jump;

    // Classify the slot and pick the target source.
    always_comb begin
        is_jump  = ex.valid && (opc_of(ex.instr) == OPC_JUMP);
        redirect = ex.valid && (is_jump || exu_taken);
        target   = is_jump ? jump_dest(ex.pc, ex.instr) : exu_target;
    end
endmodule

// File: rtl/dslot_pc_unit.sv
// Program counter with a one-entry held redirect. A redirect seen while
// fetch runs applies right after the current (delay-slot) fetch; one
// seen while fetch is blocked is parked until the delay slot goes out.
// Assumes no second redirect arrives while one is parked.
module dslot_pc_unit
    import dslot_pkg::*;
#(
    parameter word_t RESET_PC = '0
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fetch_go,
    input  logic  redirect,
    input  word_t redirect_target,
    output word_t pc,
    output logic  pend_valid,
    output word_t pend_target
);
    // Advance, redirect or hold the fetch address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc          <= RESET_PC;
            pend_valid  <= 1'b0;
            pend_target <= '0;
        end else if (redirect) begin
            if (fetch_go) begin
                pc <= redirect_target;
            end else begin
                pend_valid  <= 1'b1;
                pend_target <= redirect_target;
            end
        end else if (fetch_go) begin
            if (pend_valid) begin
                pc         <= pend_target;
                pend_valid <= 1'b0;
            end else begin
                pc <= pc + XLEN'(STEP);
            end
        end
    end
endmodule

// File: rtl/dslot_stage_regs.sv
// Execute slot and memory stage registers. A fetch fills the execute
// slot; a blocked fetch leaves a bubble. Loads and stores move on to
// the memory stage with the execute unit's computed address; other
// classes retire from the execute slot.
module dslot_stage_regs
    import dslot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fetch_go,
    input  word_t     fetch_pc,
    input  word_t     fetch_word,
    input  word_t     exu_addr,
    output ex_slot_t  ex,
    output mem_slot_t mem
);
    // Capture the fetched word, or insert a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex <= '0;
        end else begin
            ex.valid <= fetch_go;
            if (fetch_go) begin
                ex.instr <= fetch_word;
                ex.pc    <= fetch_pc;
            end
        end
    end

    // Move loads and stores into the memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            mem.valid <= ex.valid && uses_mem(ex.instr);
            mem.store <= opc_of(ex.instr) == OPC_STORE;
            mem.pc    <= ex.pc;
            mem.addr  <= exu_addr;
        end
    end
endmodule

// File: rtl/dslot_fetch_seq.sv
// Delayed-branch fetch sequencer top. One memory port is shared between
// instruction fetch and the memory stage; the memory stage wins and the
// fetch waits. Memory is assumed to answer combinationally.
module dslot_fetch_seq
    import dslot_pkg::*;
#(
    parameter word_t RESET_PC = '0
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            exu_taken,
    input  logic [XLEN-1:0] exu_target,
    input  logic [XLEN-1:0] exu_addr,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_data_acc,
    output logic            mem_we,
    output logic            ex_valid,
    output logic [XLEN-1:0] ex_instr,
    output logic [XLEN-1:0] ex_pc,
    output logic            mem_stage_valid,
    output logic [XLEN-1:0] mem_stage_pc
);
    ex_slot_t  ex;
    mem_slot_t mem;
    word_t     pc_q;
    word_t     pend_t;
    word_t     redir_tgt;
    logic      pend_v;
    logic      redir;
    logic      fetch_go;

    // Fetch runs only when the memory stage leaves the port free.
    always_comb fetch_go = !mem.valid;

    dslot_redirect u_redirect (
        .ex         (ex),
        .exu_taken  (exu_taken),
        .exu_target (exu_target),
        .redirect   (redir),
        .target     (redir_tgt)
    );

    dslot_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_go        (fetch_go),
        .redirect        (redir),
        .redirect_target (redir_tgt),
        .pc              (pc_q),
        .pend_valid      (pend_v),
        .pend_target     (pend_t)
    );

    dslot_stage_regs u_stages (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_go   (fetch_go),
        .fetch_pc   (pc_q),
        .fetch_word (mem_rdata),
        .exu_addr   (exu_addr),
        .ex         (ex),
        .mem        (mem)
    );

    // Drive the shared port and expose the stage contents.
    always_comb begin
        mem_addr        = mem.valid ? mem.addr : pc_q;
        mem_data_acc    = mem.valid;
        mem_we          = mem.valid && mem.store;
        ex_valid        = ex.valid;
        ex_instr        = ex.instr;
        ex_pc           = ex.pc;
        mem_stage_valid = mem.valid;
        mem_stage_pc    = mem.pc;
    end
endmodule

// File: rtl/dslot_fetch_seq_chk.sv
// Property checker for the fetch sequencer, bound into the top. It
// watches the program counter, the held redirect and the stage outputs.
module dslot_fetch_seq_chk
    import dslot_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input word_t pc,
    input logic  pend_valid,
    input word_t pend_target,
    input logic  fetch_go,
    input logic  redirect,
    input word_t target,
    input word_t mem_addr,
    input logic  ex_valid,
    input word_t ex_instr,
    input word_t ex_pc,
    input logic  mem_stage_valid,
    input word_t mem_stage_pc
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_addr == '0 && !ex_valid && !mem_stage_valid && !pend_valid));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && !redirect && !pend_valid) |=> (pc == $past(pc) + XLEN'(STEP)));

    p_slot_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> (ex_valid && ex_pc == $past(pc)));

    p_ls_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && uses_mem(ex_instr)) |=> (mem_stage_valid && mem_stage_pc == $past(ex_pc)));

    p_alu_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !uses_mem(ex_instr)) |=> !mem_stage_valid);

    p_stall_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stage_valid |=> !ex_valid);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_go && !redirect) |=> (pc == $past(pc)));

    p_slot_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && fetch_go) |=> (pc == $past(target)));

    p_pend_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !ex_valid);

    p_pend_apply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && fetch_go) |=> (pc == $past(pend_target) && !pend_valid));
endmodule

bind dslot_fetch_seq dslot_fetch_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pc              (pc_q),
    .pend_valid      (pend_v),
    .pend_target     (pend_t),
    .fetch_go        (fetch_go),
    .redirect        (redir),
    .target          (redir_tgt),
    .mem_addr        (mem_addr),
    .ex_valid        (ex_valid),
    .ex_instr        (ex_instr),
    .ex_pc           (ex_pc),
    .mem_stage_valid (mem_stage_valid),
    .mem_stage_pc    (mem_stage_pc)
);

// File: tb/test_dslot_fetch_seq.sv
// Bench: behavioural model of the delayed-branch pipeline, compared with
// every output at each falling edge.
module test_dslot_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 500;
    localparam int WD_CYCLES  = 5000;
    localparam logic [5:0] OP_BR = 6'b000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_rdata, exu_target, exu_addr;
    logic        exu_taken;
    logic [31:0] mem_addr, ex_instr, ex_pc, mem_stage_pc;
    logic        mem_data_acc, mem_we, ex_valid, mem_stage_valid;

    logic [31:0] prog [256];

    int n_chk = 0, n_fail = 0;
    int n_stall = 0, n_jump = 0, n_taken = 0, n_pend = 0, n_chain = 0, n_bubble = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dslot_fetch_seq i_dslot_fetch_seq (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
        .exu_taken(exu_taken), .exu_target(exu_target), .exu_addr(exu_addr),
        .mem_addr(mem_addr), .mem_data_acc(mem_data_acc), .mem_we(mem_we),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc),
        .mem_stage_valid(mem_stage_valid), .mem_stage_pc(mem_stage_pc)
    );

    // Memory and execute-unit models; taken is forced high in bubbles (R7).
    assign mem_rdata  = prog[mem_addr[9:2]];
    assign exu_taken  = ex_valid ? (ex_instr[31:26] == OP_BR && ex_instr[16]) : 1'b1;
    assign exu_target = ex_valid ? (ex_pc + 32'd4 + {{14{ex_instr[15]}}, ex_instr[15:0], 2'b00})
                                 : 32'h0000_0DEC;
    assign exu_addr   = ex_valid ? {16'h0, ex_instr[15:0]} : 32'hFFFF_FFF0;

    function automatic logic [31:0] f_alu(input int k);
        return {6'b000000, 26'(k)};
    endfunction
    function automatic logic [31:0] f_ld(input logic [15:0] a);
        return {6'b100011, 5'd1, 5'd2, a};
    endfunction
    function automatic logic [31:0] f_st(input logic [15:0] a);
        return {6'b101011, 5'd1, 5'd2, a};
    endfunction
    function automatic logic [31:0] f_br(input int from, input int to, input bit tk);
        logic [15:0] off;
        off = 16'(to - from - 1);
        return {OP_BR, 5'd0, 4'd0, tk, off};
    endfunction
    function automatic logic [31:0] f_j(input int to);
        return {6'b000010, 26'(to)};
    endfunction

    // Reference model state.
    logic [31:0] m_pc, m_ex_i, m_ex_pc, m_mem_pc, m_mem_a, last_br_pc;
    logic        m_ex_v, m_mem_v, m_mem_st, last_br_v;
    logic [31:0] tq[$];
    string       tagq[$];
    string       m_pc_tag;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(mem_data_acc === m_mem_v, "R5", "data_acc", 32'(mem_data_acc), 32'(m_mem_v));
        if (m_mem_v) begin
            chk(mem_addr === m_mem_a, "R5", "data addr", mem_addr, m_mem_a);
            chk(mem_we === m_mem_st, "R5", "we", 32'(mem_we), 32'(m_mem_st));
        end else begin
            chk(mem_addr === m_pc, m_pc_tag, "fetch addr", mem_addr, m_pc);
            chk(mem_we === 1'b0, "R5", "we on fetch", 32'(mem_we), 32'd0);
        end
        chk(ex_valid === m_ex_v, "R3", "ex_valid", 32'(ex_valid), 32'(m_ex_v));
        if (m_ex_v) begin
            chk(ex_pc === m_ex_pc, "R3", "ex_pc", ex_pc, m_ex_pc);
            chk(ex_instr === m_ex_i, "R3", "ex_instr", ex_instr, m_ex_i);
        end
        chk(mem_stage_valid === m_mem_v, "R4", "mem_valid", 32'(mem_stage_valid), 32'(m_mem_v));
        if (m_mem_v)
            chk(mem_stage_pc === m_mem_pc, "R4", "mem_pc", mem_stage_pc, m_mem_pc);
    endtask

    task automatic step();
        logic [5:0]  op;
        logic [31:0] tgt, inc;
        logic        tk, nm_v, ne_v;
        string       tg;
        op = m_ex_i[31:26];
        tk = 1'b0;
        tgt = '0;
        tg = "R8";
        if (m_ex_v) begin
            inc = m_ex_pc + 32'd4;
            if (op == 6'b000010) begin
                tk = 1'b1; tgt = {inc[31:28], m_ex_i[25:0], 2'b00}; tg = "R6"; n_jump++;
            end else if (op == OP_BR && m_ex_i[16]) begin
                tk = 1'b1; tgt = inc + {{14{m_ex_i[15]}}, m_ex_i[15:0], 2'b00};
            end
            if (tk) begin
                if (last_br_v && m_ex_pc == last_br_pc + 32'd4) begin tg = "R10"; n_chain++; end
                if (m_mem_v) begin tg = "R9"; n_pend++; end
                tq.push_back(tgt);
                tagq.push_back(tg);
                last_br_v = 1'b1;
                last_br_pc = m_ex_pc;
                n_taken++;
            end
        end else begin
            n_bubble++;
        end
        nm_v = m_ex_v && (op == 6'b100011 || op == 6'b101011);
        if (nm_v) begin
            m_mem_pc = m_ex_pc;
            m_mem_st = (op == 6'b101011);
            m_mem_a  = {16'h0, m_ex_i[15:0]};
        end
        if (!m_mem_v) begin
            ne_v    = 1'b1;
            m_ex_i  = prog[m_pc[9:2]];
            m_ex_pc = m_pc;
            if (tq.size() > 0) begin
                m_pc = tq.pop_front();
                m_pc_tag = tagq.pop_front();
            end else begin
                m_pc = m_pc + 32'd4;
                m_pc_tag = m_ex_v ? "R2" : "R7";
            end
        end else begin
            ne_v = 1'b0;
            n_stall++;
        end
        m_ex_v  = ne_v;
        m_mem_v = nm_v;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, RUN_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = f_alu(i + 1000);
        prog[2]   = f_ld(16'h0040);
        prog[4]   = f_st(16'h0080);
        prog[5]   = f_br(5, 20, 1'b1);
        prog[20]  = f_j(40);
        prog[21]  = f_br(21, 60, 1'b1);
        prog[60]  = f_br(60, 90, 1'b0);
        prog[62]  = f_ld(16'h0100);
        prog[63]  = f_br(63, 80, 1'b1);
        prog[80]  = f_br(80, 100, 1'b1);
        prog[101] = f_ld(16'h0200);
        prog[102] = f_st(16'h0204);
        prog[103] = f_j(0);
        prog[104] = f_ld(16'h0010);

        m_pc = '0; m_ex_v = 1'b0; m_ex_i = '0; m_ex_pc = '0;
        m_mem_v = 1'b0; m_mem_st = 1'b0; m_mem_pc = '0; m_mem_a = '0;
        last_br_v = 1'b0; last_br_pc = '0; m_pc_tag = "R1";

        repeat (3) @(negedge clk);
        // R1: state held during reset.
        chk(mem_addr === 32'd0, "R1", "reset addr", mem_addr, 32'd0);
        chk(mem_data_acc === 1'b0, "R1", "reset data_acc", 32'(mem_data_acc), 32'd0);
        chk(mem_we === 1'b0, "R1", "reset we", 32'(mem_we), 32'd0);
        chk(ex_valid === 1'b0, "R1", "reset ex_valid", 32'(ex_valid), 32'd0);
        chk(mem_stage_valid === 1'b0, "R1", "reset mem_valid", 32'(mem_stage_valid), 32'd0);
        rst_n = 1'b1;

        for (int c = 0; c < RUN_CYCLES; c++) begin
            compare();
            step();
            @(negedge clk);
        end

        // Coverage of the behaviours each requirement names.
        chk(n_stall > 0, "R5", "stall cycles seen", 32'(n_stall), 32'd1);
        chk(n_jump > 0, "R6", "jumps seen", 32'(n_jump), 32'd1);
        chk(n_bubble > 0, "R7", "bubbles with taken high", 32'(n_bubble), 32'd1);
        chk(n_taken > 0, "R8", "taken transfers seen", 32'(n_taken), 32'd1);
        chk(n_pend > 0, "R9", "held redirects seen", 32'(n_pend), 32'd1);
        chk(n_chain > 0, "R10", "chained branches seen", 32'(n_chain), 32'd1);

        done = 1;
        summary();
        $finish;
    end
endmodule